// File: doc/BRIEF.md
# Delayed single-shot pulse timer

A down-counting timer channel that waits a programmed delay, drives one pulse of programmed width on its output flip-flop, and then stops. Software first writes the delay into the counter and the width into a separate reload register, and then sets the enable bit. The counter counts down by one on each count-clock strobe. The first strobe that finds it at zero inverts the output and loads the width. The second such strobe inverts the output again and ends the run.

Each of the two zero crossings raises a one-cycle request that can drive an interrupt or a DMA trigger. A running flag is high from enable to completion. The live counter value is always visible. Clearing the enable bit stops the channel at once. A finished channel starts again only after a fresh counter write and a new enable.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: A counter write (`cnt_wr_i`) while the channel is not running makes `cnt_o` equal the written value on the next cycle. A counter write while running is ignored and `cnt_o` keeps counting.
- R2: An enable write of 1 sets `busy_o` on the next cycle only if a counter write has occurred since reset or since the last completion. Otherwise `busy_o` stays 0.
- R3: While running, each cycle with `tick_i` high and `cnt_o` nonzero lowers `cnt_o` by exactly one. A cycle without `tick_i` leaves it unchanged.
- R4: The first underflow inverts `out_o` and loads the reload value into the counter. An underflow is a strobe that arrives while the counter holds zero.
- R5: With preset P and reload R, `out_o` first changes on strobe number P+1 after enable and changes back on strobe number P+R+2.
- R6: `req_o` is high for exactly one cycle at each underflow, in the same cycle that `out_o` shows its new level. It is never high otherwise.
- R7: The second underflow clears `busy_o` and leaves `cnt_o` at zero. Further strobes change neither `cnt_o` nor `out_o`.
- R8: An enable write of 0 clears `busy_o` on the next cycle. A strobe in that same cycle is not counted, and `cnt_o` and `out_o` stay frozen at their current values.
- R9: After reset `out_o`, `req_o` and `busy_o` are 0 and `cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_wr_i | input | 1 | Counter preset write strobe |
| cnt_wdata_i | input | W | Counter preset value (delay) |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | W | Reload value (pulse width) |
| en_wr_i | input | 1 | Enable bit write strobe |
| en_wdata_i | input | 1 | Enable bit value |
| tick_i | input | 1 | Count-clock enable strobe |
| out_o | output | 1 | Output flip-flop level |
| req_o | output | 1 | Interrupt/DMA request pulse |
| busy_o | output | 1 | Channel running flag |
| cnt_o | output | W | Current counter value |

## Verification
The checker tests on every cycle that the count drops by exactly one per strobe while running. It also tests that an idle channel holds both its count and its output, and that a request and an output edge always occur together. Only the directed scenarios can show the end-to-end timing: the delay of P+1 and width of R+1 strobes with the strobes both back to back and spaced out, the degenerate zero preset and zero reload, the gating of enable by a fresh preset, and an output that stays high when the channel is stopped partway through the pulse.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic {
    PH_DELAY = 1'b0,
    PH_WIDTH = 1'b1
  } phase_e;
endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_pre_i,
  input  logic [W-1:0] pre_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic         load_rld_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, rld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rld_q <= '0;
    else if (rld_wr_i) rld_q <= rld_wdata_i;
  end

  // preset has priority; load and decrement are exclusive by construction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_pre_i) cnt_q <= pre_i;
    else if (load_rld_i) cnt_q <= rld_q;
    else if (dec_i)      cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ost_ctrl.sv
module ost_ctrl
  import ost_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_wr_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic tick_i,
  input  logic zero_i,
  output logic load_pre_o,
  output logic load_rld_o,
  output logic dec_o,
  output logic uflow_o,
  output logic busy_o
);
  phase_e phase_q;
  logic   run_q, armed_q;
  logic   stop_req, start_req, act, done;

  assign stop_req  = en_wr_i & ~en_wdata_i;
  assign start_req = en_wr_i & en_wdata_i & armed_q;
  // stop takes effect in the same cycle: the strobe is dropped
  assign act       = run_q & ~stop_req;
  assign dec_o     = act & tick_i & ~zero_i;
  assign uflow_o   = act & tick_i & zero_i;
  assign load_rld_o = uflow_o & (phase_q == PH_DELAY);
  assign done      = uflow_o & (phase_q == PH_WIDTH);
  assign load_pre_o = cnt_wr_i & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      phase_q <= PH_DELAY;
    end else begin
      if (stop_req || done) run_q <= 1'b0;
      else if (start_req)   run_q <= 1'b1;

      if (load_pre_o) armed_q <= 1'b1;
      else if (done)  armed_q <= 1'b0;

      if (load_pre_o)      phase_q <= PH_DELAY;
      else if (load_rld_o) phase_q <= PH_WIDTH;
      else if (done)       phase_q <= PH_DELAY;
    end
  end

  assign busy_o = run_q;
endmodule

// File: rtl/ost_outff.sv
module ost_outff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uflow_i,
  output logic out_o,
  output logic req_o
);
  logic out_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (uflow_i) out_q <= ~out_q;
      req_q <= uflow_i;
    end
  end

  assign out_o = out_q;
  assign req_o = req_q;
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic         en_wr_i,
  input  logic         en_wdata_i,
  input  logic         tick_i,
  output logic         out_o,
  output logic         req_o,
  output logic         busy_o,
  output logic [W-1:0] cnt_o
);
  logic load_pre, load_rld, dec, uflow, zero;

  ost_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_wr_i   (cnt_wr_i),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .tick_i     (tick_i),
    .zero_i     (zero),
    .load_pre_o (load_pre),
    .load_rld_o (load_rld),
    .dec_o      (dec),
    .uflow_o    (uflow),
    .busy_o     (busy_o)
  );

  ost_counter #(.W(W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_pre_i  (load_pre),
    .pre_i       (cnt_wdata_i),
    .rld_wr_i    (rld_wr_i),
    .rld_wdata_i (rld_wdata_i),
    .load_rld_i  (load_rld),
    .dec_i       (dec),
    .cnt_o       (cnt_o),
    .zero_o      (zero)
  );

  ost_outff u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .uflow_i (uflow),
    .out_o   (out_o),
    .req_o   (req_o)
  );
endmodule

// File: rtl/ost_chk.sv
module ost_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_wr_i,
  input logic         en_wr_i,
  input logic         en_wdata_i,
  input logic         tick_i,
  input logic         out_o,
  input logic         req_o,
  input logic         busy_o,
  input logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  // R3
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && cnt_o != '0 && !en_wr_i) |=> (cnt_o == $past(cnt_o) - ONE));

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !cnt_wr_i) |=> $stable(cnt_o));

  // R7
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cnt_wr_i) |=> $stable(cnt_o));

  // R8
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(out_o));

  // R6
  req_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (out_o != $past(out_o)));

  // R6
  edge_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o != $past(out_o)) |-> req_o);

  // R8
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_wdata_i) |=> (!busy_o && $stable(cnt_o)));
endmodule

bind oneshot_pulse_timer ost_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_wr_i   (cnt_wr_i),
  .en_wr_i    (en_wr_i),
  .en_wdata_i (en_wdata_i),
  .tick_i     (tick_i),
  .out_o      (out_o),
  .req_o      (req_o),
  .busy_o     (busy_o),
  .cnt_o      (cnt_o)
);

// File: tb/tb_oneshot_pulse_timer.sv
module tb_oneshot_pulse_timer;
  localparam int W = 24;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cnt_wr_i = 1'b0;
  logic [W-1:0] cnt_wdata_i = '0;
  logic         rld_wr_i = 1'b0;
  logic [W-1:0] rld_wdata_i = '0;
  logic         en_wr_i = 1'b0;
  logic         en_wdata_i = 1'b0;
  logic         tick_i = 1'b0;
  logic         out_o, req_o, busy_o;
  logic [W-1:0] cnt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  oneshot_pulse_timer #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cnt_wr_i = 0; rld_wr_i = 0; en_wr_i = 0; tick_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v;
    @(negedge clk_i);
    cnt_wr_i = 1'b0;
  endtask

  task automatic wr_rld(input logic [W-1:0] v);
    rld_wr_i = 1'b1; rld_wdata_i = v;
    @(negedge clk_i);
    rld_wr_i = 1'b0;
  endtask

  task automatic wr_en(input logic b);
    en_wr_i = 1'b1; en_wdata_i = b;
    @(negedge clk_i);
    en_wr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  // full run; gap = idle cycles between strobes
  task automatic t_pulse(input int p, input int r, input int gap);
    int n = 0, rise = -1, fall = -1, reqs = 0, bad_req = 0, rld_at_rise = -1;
    logic prev_out;
    wr_cnt(W'(p));
    chk(cnt_o == W'(p), "R1 preset", int'(cnt_o), p);
    wr_rld(W'(r));
    wr_en(1'b1);
    chk(busy_o == 1'b1, "R2 start", int'(busy_o), 1);
    prev_out = out_o;
    for (int k = 0; k < 4 * (p + r + 2) * (gap + 1) + 20; k++) begin
      tick_i = (k % (gap + 1) == 0);
      @(negedge clk_i);
      if (tick_i) n++;
      if (req_o) reqs++;
      if (req_o != (out_o != prev_out)) bad_req++;
      if (out_o && rise < 0) begin rise = n; rld_at_rise = int'(cnt_o); end
      if (!out_o && rise >= 0 && fall < 0) fall = n;
      prev_out = out_o;
      if (!busy_o) break;
    end
    tick_i = 1'b0;
    chk(rise == p + 1, "R5 delay", rise, p + 1);
    chk(rld_at_rise == r, "R4 reload", rld_at_rise, r);
    chk(fall == p + r + 2, "R5 width", fall, p + r + 2);
    chk(reqs == 2, "R6 req count", reqs, 2);
    chk(bad_req == 0, "R6 req align", bad_req, 0);
    chk(!busy_o && cnt_o == '0, "R7 done", int'(cnt_o), 0);
    ticks(3);
    chk(cnt_o == '0 && !out_o && !req_o, "R7 no change", int'(cnt_o), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!out_o && !req_o && !busy_o && cnt_o == '0, "R9 reset",
        int'({out_o, req_o, busy_o}), 0);
  endtask

  task automatic t_rearm();
    // channel has just completed
    wr_en(1'b1);
    chk(busy_o == 1'b0, "R2 no rearm", int'(busy_o), 0);
    ticks(2);
    chk(cnt_o == '0 && !out_o, "R2 idle", int'(cnt_o), 0);
    wr_cnt(W'(5));
    chk(cnt_o == W'(5), "R1 reload preset", int'(cnt_o), 5);
    wr_en(1'b1);
    chk(busy_o == 1'b1, "R2 rearm", int'(busy_o), 1);
    wr_en(1'b0);
  endtask

  task automatic t_stop_delay();
    do_reset();
    wr_cnt(W'(10));
    wr_rld(W'(3));
    wr_en(1'b1);
    ticks(4);
    chk(cnt_o == W'(6), "R3 decrement", int'(cnt_o), 6);
    wr_cnt(W'(99));
    chk(cnt_o == W'(6), "R1 ignored while running", int'(cnt_o), 6);
    tick_i = 1'b1;
    wr_en(1'b0);
    tick_i = 1'b0;
    chk(!busy_o && cnt_o == W'(6), "R8 stop same cycle", int'(cnt_o), 6);
    ticks(3);
    chk(cnt_o == W'(6) && !out_o, "R8 frozen", int'(cnt_o), 6);
  endtask

  task automatic t_stop_pulse();
    do_reset();
    wr_cnt(W'(1));
    wr_rld(W'(5));
    wr_en(1'b1);
    ticks(2);
    chk(out_o == 1'b1, "R4 first flip", int'(out_o), 1);
    wr_en(1'b0);
    ticks(4);
    chk(out_o == 1'b1 && !busy_o && !req_o, "R8 level held", int'(out_o), 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pulse(3, 2, 0);
    t_rearm();
    do_reset();
    t_pulse(2, 4, 2);
    do_reset();
    t_pulse(0, 0, 0);
    do_reset();
    t_pulse(20, 7, 1);
    t_stop_delay();
    t_stop_pulse();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule